// File: doc/BRIEF.md
# Reset Start-Up Sequencer

This block merges four reset requests (power-on, external pin, watchdog and supply monitor) into one internal reset. The reset goes high as soon as any request appears. It is released only after every request has gone away and three counted phases have run in a fixed order: a long delay counted on a slow oscillator tick, an oscillator start-up wait counted on main-oscillator ticks, and a configuration-load phase counted on the system clock. The configuration-load phase drives a strobe for its whole duration. A register of cause flags records which request caused the most recent resets.

The sequence is held in an enumerated state machine. `ST_HOLD` lasts while any request is high. `ST_DELAY` counts `DELAY_TICKS` slow ticks, `ST_OSC` counts `OSC_CYCLES` oscillator ticks, and `ST_CFG` lasts `CFG_CYCLES` clocks. `ST_RUN` is normal operation. Power-down is handled by two further states. `ST_DOWN` is entered from `ST_RUN` on a sleep request. `ST_WAKE` is entered from `ST_DOWN` on a wake request, counts only the oscillator start-up ticks and returns to `ST_RUN`. The internal reset stays low on this path.

Transitions:
- HOLD→DELAY when all requests are low.
- DELAY→OSC on the last slow tick.
- OSC→CFG on the last oscillator tick.
- CFG→RUN on the last configuration clock.
- RUN→DOWN on sleep.
- DOWN→WAKE on wake.
- WAKE→RUN on the last oscillator tick.
- Any state→HOLD while a request is high.

Top module: `startup_reset_seq`

## Requirements
- R1: `rst_out` is high whenever any of `por_req`, `pin_req`, `wdt_req`, `sup_req` is high, with no clock edge needed. `por_req` also resets the sequencer asynchronously.
- R2: After all requests are low, `rst_out` stays high through the delay, oscillator and configuration phases, in that order. It goes low in the cycle after the last configuration clock.
- R3: The delay phase ends on the `DELAY_TICKS`-th `slow_tick` sampled after the first clock edge at which all requests are low. Ticks seen while a request is high, such as during a watchdog pulse, are not counted.
- R4: The oscillator phase ends on the `OSC_CYCLES`-th `osc_tick` after the delay phase ends. `slow_tick` has no effect in this phase. `osc_ready` is low until the configuration phase begins.
- R5: `cfg_load` is high for exactly `CFG_CYCLES` consecutive clocks, immediately before `rst_out` falls.
- R6: A request arriving in any phase aborts the sequence. `cfg_load` falls, and the whole delay is counted again after the request ends.
- R7: In run state, `sleep_req` enters power-down, where `osc_ready` is low and `rst_out` stays low. `wake_req` then counts only `OSC_CYCLES` oscillator ticks before `osc_ready` returns high, with no delay phase and no reset.
- R8: `cause_flags` bit 0 marks power-on, bit 1 pin, bit 2 watchdog and bit 3 supply monitor. A power-on request sets it to 4'b0001.
- R9: A pin, watchdog or supply request sets only its own flag and leaves the other bits unchanged.
- R10: A write with `flag_wr_en` ANDs `cause_flags` with `flag_wr_data`, so a written 0 clears a bit and a written 1 leaves it. A request in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on reset request, also the asynchronous reset |
| pin_req | input | 1 | External pin reset request |
| wdt_req | input | 1 | Watchdog reset request pulse |
| sup_req | input | 1 | Supply-monitor reset request |
| slow_tick | input | 1 | One-clock pulse per slow-oscillator cycle |
| osc_tick | input | 1 | One-clock pulse per main-oscillator cycle |
| sleep_req | input | 1 | Enter power-down from run state |
| wake_req | input | 1 | Wake request from power-down |
| flag_wr_en | input | 1 | Cause-flag write strobe |
| flag_wr_data | input | 4 | Cause-flag write mask (AND) |
| rst_out | output | 1 | Internal reset, active high |
| cfg_load | output | 1 | Configuration-load strobe |
| osc_ready | output | 1 | Main oscillator considered stable |
| cause_flags | output | 4 | Reset-cause flags |

## Verification
`rst_out` follows a request within the same cycle, without an edge. The bench checks it 1 ns after driving the request. Every other output changes one edge after the input that causes it. The bench drives inputs on falling edges and samples on the next falling edge, so the sample reflects exactly one rising edge.

For each release sequence the bench generates ticks with periods it chooses. From those periods it computes the index of the edge that ends each phase. It then compares the number of samples with `rst_out` high, `cfg_load` high and `osc_ready` low against those indices. The wake path is measured the same way against six oscillator ticks.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_DELAY,
        ST_OSC,
        ST_CFG,
        ST_RUN,
        ST_DOWN,
        ST_WAKE
    } rsq_state_e;

    localparam int CAUSE_POR = 0;
    localparam int CAUSE_PIN = 1;
    localparam int CAUSE_WDT = 2;
    localparam int CAUSE_SUP = 3;
    localparam int CAUSE_N   = 4;

endpackage

// File: rtl/rsq_phase_counter.sv
module rsq_phase_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] lim,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;

    assign hit = inc && (cnt_q == lim - CNT_W'(1));

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (arst)
        cnt_q < lim);

endmodule

// File: rtl/rsq_cause_flags.sv
module rsq_cause_flags
    import rsq_pkg::*;
(
    input  logic               clk,
    input  logic               por_req,
    input  logic               pin_req,
    input  logic               wdt_req,
    input  logic               sup_req,
    input  logic               wr_en,
    input  logic [CAUSE_N-1:0] wr_data,
    output logic [CAUSE_N-1:0] flags
);

    logic [CAUSE_N-1:0] set_vec;
    logic [CAUSE_N-1:0] flags_q;

    always_comb begin
        set_vec            = '0;
        set_vec[CAUSE_PIN] = pin_req;
        set_vec[CAUSE_WDT] = wdt_req;
        set_vec[CAUSE_SUP] = sup_req;
    end

    for (genvar b = 0; b < CAUSE_N; b++) begin : g_flag
        always_ff @(posedge clk or posedge por_req) begin
            if (por_req) begin
                flags_q[b] <= (b == CAUSE_POR);
            end else if (set_vec[b]) begin
                flags_q[b] <= 1'b1;
            end else if (wr_en && !wr_data[b]) begin
                flags_q[b] <= 1'b0;
            end
        end
    end

    assign flags = flags_q;

    // R8
    por_flag_rise_chk: assert property (@(posedge clk) disable iff (por_req)
        !$rose(flags_q[CAUSE_POR]));

    // R9
    pin_flag_rise_chk: assert property (@(posedge clk) disable iff (por_req)
        $rose(flags_q[CAUSE_PIN]) |-> $past(pin_req));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(flags_q[CAUSE_WDT]) |-> ($past(wr_en) && !$past(wr_data[CAUSE_WDT])));

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int DELAY_TICKS = 8192,
    parameter int OSC_CYCLES  = 6,
    parameter int CFG_CYCLES  = 21
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             any_req,
    input  logic             slow_tick,
    input  logic             osc_tick,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic             hit,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic [CNT_W-1:0] cnt_lim,
    output logic             in_reset,
    output logic             cfg_load,
    output logic             osc_ready
);

    rsq_state_e state_q;
    rsq_state_e state_d;

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_DELAY;
            ST_DELAY: if (hit) state_d = ST_OSC;
            ST_OSC:   if (hit) state_d = ST_CFG;
            ST_CFG:   if (hit) state_d = ST_RUN;
            ST_RUN:   if (sleep_req) state_d = ST_DOWN;
            ST_DOWN:  if (wake_req) state_d = ST_WAKE;
            ST_WAKE:  if (hit) state_d = ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
        if (any_req) begin
            state_d = ST_HOLD;
        end
    end

    // outputs and counter control
    always_comb begin
        in_reset  = 1'b1;
        cfg_load  = 1'b0;
        osc_ready = 1'b0;
        cnt_inc   = 1'b0;
        cnt_lim   = CNT_W'(OSC_CYCLES);
        unique case (state_q)
            ST_HOLD: begin
                cnt_lim = CNT_W'(DELAY_TICKS);
            end
            ST_DELAY: begin
                cnt_inc = slow_tick;
                cnt_lim = CNT_W'(DELAY_TICKS);
            end
            ST_OSC: begin
                cnt_inc = osc_tick;
            end
            ST_CFG: begin
                cnt_inc   = 1'b1;
                cnt_lim   = CNT_W'(CFG_CYCLES);
                cfg_load  = 1'b1;
                osc_ready = 1'b1;
            end
            ST_RUN: begin
                in_reset  = 1'b0;
                osc_ready = 1'b1;
            end
            ST_DOWN: begin
                in_reset = 1'b0;
            end
            ST_WAKE: begin
                in_reset = 1'b0;
                cnt_inc  = osc_tick;
            end
            default: begin
                in_reset = 1'b1;
            end
        endcase
        cnt_clr = (state_d != state_q);
    end

    // R2
    osc_entry_chk: assert property (@(posedge clk) disable iff (arst)
        (state_q == ST_OSC && $past(state_q) != ST_OSC) |-> $past(state_q) == ST_DELAY);

    // R2
    cfg_entry_chk: assert property (@(posedge clk) disable iff (arst)
        (state_q == ST_CFG && $past(state_q) != ST_CFG) |-> $past(state_q) == ST_OSC);

    // R2
    run_entry_chk: assert property (@(posedge clk) disable iff (arst)
        (state_q == ST_RUN && $past(state_q) != ST_RUN)
        |-> ($past(state_q) == ST_CFG || $past(state_q) == ST_WAKE));

    // R7
    wake_entry_chk: assert property (@(posedge clk) disable iff (arst)
        (state_q == ST_WAKE) |-> ($past(state_q) == ST_DOWN || $past(state_q) == ST_WAKE));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (arst)
        $past(any_req) |-> state_q == ST_HOLD);

endmodule

// File: rtl/startup_reset_seq.sv
module startup_reset_seq
    import rsq_pkg::*;
#(
    parameter int DELAY_TICKS = 8192,
    parameter int OSC_CYCLES  = 6,
    parameter int CFG_CYCLES  = 21
) (
    input  logic         clk,
    input  logic         por_req,
    input  logic         pin_req,
    input  logic         wdt_req,
    input  logic         sup_req,
    input  logic         slow_tick,
    input  logic         osc_tick,
    input  logic         sleep_req,
    input  logic         wake_req,
    input  logic         flag_wr_en,
    input  logic [3:0]   flag_wr_data,
    output logic         rst_out,
    output logic         cfg_load,
    output logic         osc_ready,
    output logic [3:0]   cause_flags
);

    localparam int MAX_A = (DELAY_TICKS > OSC_CYCLES) ? DELAY_TICKS : OSC_CYCLES;
    localparam int MAX_V = (MAX_A > CFG_CYCLES) ? MAX_A : CFG_CYCLES;
    localparam int CNT_W = $clog2(MAX_V + 1);

    logic             any_req;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_lim;
    logic             cnt_hit;
    logic             in_reset;

    assign any_req = por_req | pin_req | wdt_req | sup_req;

    rsq_fsm #(
        .CNT_W      (CNT_W),
        .DELAY_TICKS(DELAY_TICKS),
        .OSC_CYCLES (OSC_CYCLES),
        .CFG_CYCLES (CFG_CYCLES)
    ) i_fsm (
        .clk      (clk),
        .arst     (por_req),
        .any_req  (any_req),
        .slow_tick(slow_tick),
        .osc_tick (osc_tick),
        .sleep_req(sleep_req),
        .wake_req (wake_req),
        .hit      (cnt_hit),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .cnt_lim  (cnt_lim),
        .in_reset (in_reset),
        .cfg_load (cfg_load),
        .osc_ready(osc_ready)
    );

    rsq_phase_counter #(
        .CNT_W(CNT_W)
    ) i_cnt (
        .clk (clk),
        .arst(por_req),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .lim (cnt_lim),
        .hit (cnt_hit)
    );

    rsq_cause_flags i_flags (
        .clk    (clk),
        .por_req(por_req),
        .pin_req(pin_req),
        .wdt_req(wdt_req),
        .sup_req(sup_req),
        .wr_en  (flag_wr_en),
        .wr_data(flag_wr_data),
        .flags  (cause_flags)
    );

    assign rst_out = any_req | in_reset;

    // R5
    cfg_release_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(rst_out) && !$past(any_req) |-> $past(cfg_load));

    // R7
    down_no_reset_chk: assert property (@(posedge clk) disable iff (por_req)
        ($past(sleep_req) && !$past(rst_out) && !$past(any_req)) |-> !osc_ready);

endmodule

// File: tb/test_startup_reset_seq.sv
module test_startup_reset_seq;

    localparam int TB_DELAY = 8;
    localparam int TB_OSC   = 6;
    localparam int TB_CFG   = 21;

    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic       pin_req = 1'b0;
    logic       wdt_req = 1'b0;
    logic       sup_req = 1'b0;
    logic       slow_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       flag_wr_en = 1'b0;
    logic [3:0] flag_wr_data = 4'h0;
    logic       rst_out;
    logic       cfg_load;
    logic       osc_ready;
    logic [3:0] cause_flags;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    startup_reset_seq #(
        .DELAY_TICKS(TB_DELAY),
        .OSC_CYCLES (TB_OSC),
        .CFG_CYCLES (TB_CFG)
    ) i_startup_reset_seq (
        .clk         (clk),
        .por_req     (por_req),
        .pin_req     (pin_req),
        .wdt_req     (wdt_req),
        .sup_req     (sup_req),
        .slow_tick   (slow_tick),
        .osc_tick    (osc_tick),
        .sleep_req   (sleep_req),
        .wake_req    (wake_req),
        .flag_wr_en  (flag_wr_en),
        .flag_wr_data(flag_wr_data),
        .rst_out     (rst_out),
        .cfg_load    (cfg_load),
        .osc_ready   (osc_ready),
        .cause_flags (cause_flags)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // index of the edge that ends the oscillator phase, counted from the
    // first edge with all requests low
    function automatic int osc_end(input int sp, input int op);
        int pa = TB_DELAY * sp - 1;
        int n  = 0;
        for (int i = pa + 1; i < pa + 1000; i++) begin
            if (i % op == op - 1) begin
                n++;
                if (n == TB_OSC) return i;
            end
        end
        return -1;
    endfunction

    // starts at a falling edge with requests just dropped
    task automatic run_seq(input int sp, input int op, input bit stop_cfg,
                           output int hi, output int cf, output int ol);
        hi = 0; cf = 0; ol = 0;
        for (int i = 0; i < 4000; i++) begin
            slow_tick = (i % sp == sp - 1);
            osc_tick  = (i % op == op - 1);
            @(negedge clk);
            if (!rst_out) break;
            hi++;
            if (cfg_load) cf++;
            if (!osc_ready) ol++;
            if (stop_cfg && cfg_load) break;
        end
        slow_tick = 1'b0;
        osc_tick  = 1'b0;
    endtask

    task automatic check_seq(input string tag, input int sp, input int op);
        int hi, cf, ol, pb;
        pb = osc_end(sp, op);
        run_seq(sp, op, 1'b0, hi, cf, ol);
        check({tag, " R2/R3 reset length"}, hi, pb + TB_CFG);
        check({tag, " R5 cfg_load length"}, cf, TB_CFG);
        check({tag, " R4 osc_ready low length"}, ol, pb);
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int hi, cf, ol, sp, op, src, hold;
        void'($urandom(32'd2718));

        // reset state, R1 with no edge yet
        #1;
        check("R1 reset with no clock edge", rst_out, 1);
        @(negedge clk);
        @(negedge clk);
        check("R8 power-on flags", cause_flags, 4'b0001);
        check("R5 cfg_load low in hold", cfg_load, 0);
        check("R4 osc_ready low in hold", osc_ready, 0);

        // power-on release, slow ticks every 3, osc every 2
        por_req = 1'b0;
        check_seq("por", 3, 2);
        check("R8 flags after release", cause_flags, 4'b0001);

        // R1: watchdog pulse asserts reset immediately
        wdt_req = 1'b1;
        #1;
        check("R1 watchdog async assert", rst_out, 1);
        // R3: ticks during the pulse are ignored
        for (int i = 0; i < 4; i++) begin
            slow_tick = (i % 2 == 1);
            osc_tick  = 1'b1;
            @(negedge clk);
        end
        wdt_req = 1'b0;
        check_seq("wdt", 4, 3);
        check("R9 watchdog flag", cause_flags, 4'b0101);

        // R10: write clears only zeroed bits
        flag_wr_en = 1'b1; flag_wr_data = 4'b1011;
        @(negedge clk);
        flag_wr_en = 1'b0;
        @(negedge clk);
        check("R10 clear by zero", cause_flags, 4'b0001);

        // R6: abort during configuration phase
        pin_req = 1'b1;
        @(negedge clk);
        pin_req = 1'b0;
        run_seq(2, 2, 1'b1, hi, cf, ol);
        check("R6 reached cfg phase", cf, 1);
        pin_req = 1'b1;
        @(negedge clk);
        check("R6 cfg aborted", cfg_load, 0);
        check("R6 reset held", rst_out, 1);
        @(negedge clk);
        pin_req = 1'b0;
        check_seq("restart", 2, 2);
        check("R9 pin flag", cause_flags, 4'b0011);

        // R10: set wins over a clearing write in the same cycle
        pin_req = 1'b1; flag_wr_en = 1'b1; flag_wr_data = 4'b0000;
        @(negedge clk);
        pin_req = 1'b0; flag_wr_en = 1'b0;
        @(negedge clk);
        check("R10 set beats clear", cause_flags, 4'b0010);
        check_seq("pin", 2, 3);

        // R7: power-down and wake
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check("R7 down osc_ready", osc_ready, 0);
        check("R7 down no reset", rst_out, 0);
        begin
            int low = 0;
            int rst_seen = 0;
            op = 3;
            for (int i = 0; i < 200; i++) begin
                wake_req = (i == 0);
                osc_tick = (i % op == op - 1);
                slow_tick = 1'b1;
                @(negedge clk);
                if (rst_out) rst_seen++;
                if (osc_ready) break;
                low++;
            end
            wake_req = 1'b0; osc_tick = 1'b0; slow_tick = 1'b0;
            check("R7 wake length", low, TB_OSC * op - 1);
            check("R7 wake no reset", rst_seen, 0);
        end

        // random sources and tick periods
        for (int k = 0; k < 5; k++) begin
            src  = $urandom % 3;
            sp   = 2 + $urandom % 4;
            op   = 2 + $urandom % 3;
            hold = 1 + $urandom % 7;
            flag_wr_en = 1'b1; flag_wr_data = 4'b0000;
            @(negedge clk);
            flag_wr_en = 1'b0;
            pin_req = (src == 0); wdt_req = (src == 1); sup_req = (src == 2);
            for (int i = 0; i < hold; i++) begin
                slow_tick = 1'b1;
                osc_tick  = 1'b1;
                @(negedge clk);
            end
            pin_req = 1'b0; wdt_req = 1'b0; sup_req = 1'b0;
            check_seq("random", sp, op);
            check("R9 random cause flag", cause_flags, 1 << (src + 1));
        end

        // R8: power-on overrides all flags
        sup_req = 1'b1;
        @(negedge clk);
        sup_req = 1'b0;
        por_req = 1'b1;
        @(negedge clk);
        check("R8 por clears others", cause_flags, 4'b0001);
        por_req = 1'b0;
        check_seq("por2", 2, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule